// File: doc/BRIEF.md
# Double-Buffered Result Store with Completion Interrupt

This block is the output stage of a matrix decomposition engine. The engine streams its result words (the triangular matrix and the update vector) into one of two result banks, called even and odd. A host processor meanwhile fetches the previous result set from the other bank. When a run has delivered its last word, the banks trade roles. The block then pulses a done flag and raises an interrupt that stays up until the host acknowledges it. The host therefore always reads a complete result set that no write can disturb, while the next set is being built.

A run begins with a start strobe, which sets the write counter to zero. Each valid result word is stored at the next write address. The terminal count of the write counter closes the write phase. The host reads through a streaming port. Each read strobe returns the word at the read counter one cycle later and advances that counter. The read counter returns to zero at every bank swap and wraps after the last word of a set. In each bank, an address multiplexer passes the write address when that bank is the write target and the read address when it is not.

Top module: `pp_result_store`

## Requirements
- R1: After reset, done and irq are 0, wr_bank is 0 (the even bank is the write target) and host_rd_data is 0.
- R2: During a run, the accepted result words are stored at consecutive addresses starting at 0, in their order of arrival. After the run completes, host reads return them in the same order.
- R3: When the RESULT_WORDS-th word of a run is accepted, done is 1 for exactly the one following cycle and the write phase ends.
- R4: wr_bank toggles (0 = even, 1 = odd) in the cycle that done is 1 and at no other time.
- R5: res_valid while no run is active is ignored. It stores nothing in either bank and raises no done.
- R6: irq rises together with done and stays 1 until a cycle in which host_ack is 1 and done is not being raised. A completion in the same cycle as an acknowledge leaves irq at 1.
- R7: Host reads issued while the next run is writing return the words of the most recently completed run, unchanged.
- R8: The read counter returns to 0 at each bank swap. After reading word RESULT_WORDS-1 it wraps to word 0.
- R9: run_start during an active run restarts the run at address 0 without a swap. res_valid in the same cycle as run_start is dropped.
- R10: host_rd_data presents the requested word in the cycle after the host_rd strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_start | input | 1 | Starts (or restarts) a run; write counter to 0 |
| res_valid | input | 1 | Result word valid from the decomposer |
| res_data | input | DATA_W | Result word |
| host_rd | input | 1 | Host read strobe; reads at the read counter and advances it |
| host_rd_data | output | DATA_W | Word read, valid one cycle after host_rd |
| host_ack | input | 1 | Host acknowledge; clears irq |
| done | output | 1 | One-cycle pulse after the last word of a run |
| irq | output | 1 | Completion interrupt, held until acknowledged |
| wr_bank | output | 1 | Current write bank, 0 even, 1 odd |

## Verification
The last accepted word of a run is captured at a clock edge. done, irq and the new wr_bank appear right after that edge, and a read strobe sets host_rd_data at that same edge. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares every output on the next falling edge against a model that was advanced by exactly that edge. Read expectations are taken from the model before the swap is applied, so a read in the completion cycle is still served from the old bank.

// File: rtl/pp_store_pkg.sv
// Shared names for the double-buffered result store.
// Assumes two banks only; the bank index is a single bit.
package pp_store_pkg;
    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;
endpackage

// File: rtl/pps_wr_ctr.sv
// Write address counter: zeroed by start, advanced per accepted word,
// terminal count at WORDS-1 closes the write phase.
// Assumes WORDS <= 2**ADDR_W. Start wins over a word in the same cycle.
module pps_wr_ctr #(
    parameter int ADDR_W = 6,
    parameter int WORDS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic              accept,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

    logic active;

    // Accept a word only inside a run and not on a start cycle.
    always_comb begin
        accept = active && valid && !start;
        last   = accept && (addr == LAST_ADDR);
    end

    // Track the run and step the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            active <= 1'b0;
        end else if (start) begin
            addr   <= '0;
            active <= 1'b1;
        end else if (accept) begin
            if (last) begin
                addr   <= '0;
                active <= 1'b0;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pps_rd_ctr.sv
// Read address counter: advanced per host read, wraps after WORDS-1,
// cleared on a bank swap (clear wins over step).
module pps_rd_ctr #(
    parameter int ADDR_W = 6,
    parameter int WORDS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

    // Step, wrap or clear the read address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (clear)
            addr <= '0;
        else if (step)
            addr <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
    end
endmodule

// File: rtl/pps_bank.sv
// One result bank with its own address multiplexer. rd_wr=1 makes this
// bank the write target (write address used), rd_wr=0 the read source.
// Read data is registered and held between reads; storage has no reset.
module pps_bank #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] mem_addr;

    // Address multiplexer steered by the bank role.
    always_comb mem_addr = rd_wr ? wr_addr : rd_addr;

    // Store a word only while this bank is the write target.
    always_ff @(posedge clk) begin
        if (we && rd_wr)
            mem[mem_addr] <= wdata;
    end

    // Register read data only while this bank is the read source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re && !rd_wr)
            rdata <= mem[mem_addr];
    end
endmodule

// File: rtl/pp_result_store.sv
// Double-buffered result store. Words of a run go to the write bank,
// the host reads the other one. On the last word the banks swap, done
// pulses for one cycle and irq is set until host_ack.
// Assumes RESULT_WORDS <= 2**ADDR_W.
module pp_result_store
    import pp_store_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 6,
    parameter int RESULT_WORDS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_start,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rd_data,
    input  logic              host_ack,
    output logic              done,
    output logic              irq,
    output logic              wr_bank
);
    localparam int NBANK = 2;

    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_accept, wr_last;
    bank_e             wbank, rd_src;
    logic [DATA_W-1:0] bank_rdata [NBANK];

    pps_wr_ctr #(.ADDR_W(ADDR_W), .WORDS(RESULT_WORDS)) u_wr_ctr (
        .clk(clk), .rst_n(rst_n), .start(run_start), .valid(res_valid),
        .addr(wr_addr), .accept(wr_accept), .last(wr_last)
    );

    pps_rd_ctr #(.ADDR_W(ADDR_W), .WORDS(RESULT_WORDS)) u_rd_ctr (
        .clk(clk), .rst_n(rst_n), .clear(wr_last), .step(host_rd),
        .addr(rd_addr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic is_wr;
        always_comb is_wr = (wbank == bank_e'(b));
        pps_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .rd_wr(is_wr),
            .wr_addr(wr_addr), .rd_addr(rd_addr),
            .we(wr_accept), .wdata(res_data),
            .re(host_rd), .rdata(bank_rdata[b])
        );
    end

    // Swap banks and raise done and irq on the terminal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbank <= BANK_EVEN;
            done  <= 1'b0;
            irq   <= 1'b0;
        end else begin
            done <= wr_last;
            if (wr_last)
                wbank <= (wbank == BANK_EVEN) ? BANK_ODD : BANK_EVEN;
            if (wr_last)
                irq <= 1'b1;
            else if (host_ack)
                irq <= 1'b0;
        end
    end

    // Remember which bank served the last host read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_src <= BANK_ODD;
        else if (host_rd)
            rd_src <= (wbank == BANK_EVEN) ? BANK_ODD : BANK_EVEN;
    end

    // Present the read word from the bank that served it.
    always_comb begin
        host_rd_data = bank_rdata[rd_src];
        wr_bank      = wbank;
    end
endmodule

// File: rtl/pps_checker.sv
// Protocol checker for the result store, bound to the top module.
module pps_checker (
    input logic clk,
    input logic rst_n,
    input logic res_valid,
    input logic host_ack,
    input logic done,
    input logic irq,
    input logic wr_bank
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_DONE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_valid)); // R5

    AST_SWAP_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_bank) |-> done); // R4

    AST_DONE_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$stable(wr_bank)); // R4

    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq); // R6

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done); // R6

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !host_ack) |=> irq); // R6
endmodule

bind pp_result_store pps_checker u_pps_checker (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .host_ack(host_ack),
    .done(done), .irq(irq), .wr_bank(wr_bank)
);

// File: tb/pp_result_store_test.sv
module pp_result_store_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 6;
    localparam int NW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_start = 1'b0, res_valid = 1'b0, host_rd = 1'b0, host_ack = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [DW-1:0] host_rd_data;
    logic done, irq, wr_bank;

    int nvec = 0, nerr = 0;
    bit finished = 1'b0;
    string rd_tag = "R10 R2";

    // bench model
    logic [DW-1:0] m_mem [2][64];
    int  m_wbank = 0, m_wcnt = 0, m_rcnt = 0;
    bit  m_active = 0, m_irq = 0, m_done = 0, m_pend = 0;
    logic [DW-1:0] m_rd = '0;

    pp_result_store #(.DATA_W(DW), .ADDR_W(AW), .RESULT_WORDS(NW)) uut (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .res_valid(res_valid),
        .res_data(res_data), .host_rd(host_rd), .host_rd_data(host_rd_data),
        .host_ack(host_ack), .done(done), .irq(irq), .wr_bank(wr_bank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] read_expect(int bank, int addr);
        return m_mem[bank][addr];
    endfunction

    // One cycle: drive at falling edge, advance model by one rising edge, check.
    task automatic step(input bit st, input bit wv, input logic [DW-1:0] wd,
                        input bit rd, input bit ack);
        bit last;
        run_start = st; res_valid = wv; res_data = wd; host_rd = rd; host_ack = ack;
        m_pend = rd;
        if (rd) begin
            m_rd = read_expect(1 - m_wbank, m_rcnt);
            m_rcnt = (m_rcnt == NW-1) ? 0 : m_rcnt + 1;
        end
        last = 0;
        if (st) begin
            m_wcnt = 0; m_active = 1;
        end else if (wv && m_active) begin
            m_mem[m_wbank][m_wcnt] = wd;
            if (m_wcnt == NW-1) begin
                m_active = 0; m_wcnt = 0; last = 1;
            end else m_wcnt++;
        end
        if (last) begin
            m_wbank = 1 - m_wbank; m_rcnt = 0;
        end
        m_done = last;
        m_irq = last ? 1'b1 : (ack ? 1'b0 : m_irq);
        @(posedge clk);
        @(negedge clk);
        chk(done == m_done, "R3", DW'(done), DW'(m_done));
        chk(irq == m_irq, "R6", DW'(irq), DW'(m_irq));
        chk(wr_bank == m_wbank[0], "R4", DW'(wr_bank), DW'(m_wbank));
        if (m_pend) chk(host_rd_data == m_rd, rd_tag, host_rd_data, m_rd);
    endtask

    task automatic idle();
        step(0, 0, '0, 0, 0);
    endtask

    task automatic run_words(input bit rd_mix, input bit ack_mix);
        step(1, 0, '0, 0, 0);
        while (m_active)
            step(0, ($urandom % 4) != 0, $urandom, rd_mix && ($urandom % 2 == 1),
                 ack_mix && ($urandom % 8 == 0));
    endtask

    task automatic read_n(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 1, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 64; a++) m_mem[b][a] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(done == 1'b0, "R1", DW'(done), 0);
        chk(irq == 1'b0, "R1", DW'(irq), 0);
        chk(wr_bank == 1'b0, "R1", DW'(wr_bank), 0);
        chk(host_rd_data == '0, "R1", host_rd_data, 0);

        // R2 R3: first run without reads, then read it back in order
        run_words(0, 0);
        step(0, 0, '0, 0, 1);
        rd_tag = "R10 R2";
        read_n(NW);

        // R5: stray words with no run are ignored; bank content stays
        for (int i = 0; i < 5; i++) step(0, 1, $urandom, 0, 0);
        rd_tag = "R5 R8";
        read_n(NW + 2);

        // R7: reads of the completed bank while the next run writes
        rd_tag = "R7";
        run_words(1, 0);

        // R8: partial read, then a new run; read restarts at word 0
        rd_tag = "R8";
        read_n(3);
        run_words(0, 0);
        read_n(4);

        // R9: restart in mid-run, with a dropped word on the start cycle
        rd_tag = "R9";
        step(1, 0, '0, 0, 1);
        for (int i = 0; i < 7; i++) step(0, 1, $urandom, 0, 0);
        step(1, 1, 32'hDEAD_BEEF, 0, 0);
        for (int i = 0; i < NW; i++) step(0, 1, $urandom, 0, 0);
        read_n(NW);

        // R6: acknowledge in the same cycle as completion keeps irq set
        step(1, 0, '0, 0, 0);
        for (int i = 0; i < NW - 1; i++) step(0, 1, $urandom, 0, 0);
        step(0, 1, $urandom, 0, 1);
        chk(irq == 1'b1, "R6", DW'(irq), 1);
        idle();
        step(0, 0, '0, 0, 1);
        chk(irq == 1'b0, "R6", DW'(irq), 0);

        // random mix of runs, reads and acknowledges
        rd_tag = "R7";
        for (int r = 0; r < 30; r++) begin
            run_words(1, 1);
            for (int i = 0; i < int'($urandom % 6); i++)
                step(0, $urandom % 2 == 1, $urandom, $urandom % 2 == 1, $urandom % 3 == 0);
        end
        idle();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule